// File: doc/BRIEF.md
# Frame Memory Rectangle Mover

This block copies a rectangle of 16-bit pixels in either direction between a 32-bit word stream and a frame memory of 1024 columns by 512 rows. A start strobe supplies a position word, a size word and a direction flag. The engine then walks the rectangle row by row. For writes, each incoming word is split into two pixel writes. For reads, the engine fetches two pixels, packs them into one outgoing word and holds that word until the consumer accepts it.

The rectangle walker keeps its row, its column offset and the number of rows left. A stream may therefore pause at any point, including partway through a row, and the next burst continues at the pixel where the previous one stopped. Rows wrap modulo 512 and columns wrap modulo 1024. A read transfer raises a status flag for as long as it has data still to deliver. A one-cycle completion pulse marks the end of every transfer.

Top module: `vram_xfer_engine`

## Requirements
- R1: After reset, busy, done, img_ready, in_ready, out_valid, mem_we and mem_re are all 0.
- R2: Start column X is start_pos[9:0] and start row Y is start_pos[24:16]. All other position bits are ignored. The pixel at column offset k of the current row goes to halfword address Y*1024 + ((X+k) mod 1024).
- R3: Width is start_size[15:0] and height is start_size[31:16]. Pixels are visited in row-major order. After the last column of a row, the offset returns to 0, Y advances by one and one fewer row remains. busy drops once every pixel has moved.
- R4: The row number wraps from 511 to 0.
- R5: The column X+offset wraps from 1023 to 0 within the same row.
- R6: In a write transfer, bits 15:0 of an accepted in_data word are written first and bits 31:16 are written in the following cycle. in_ready is low while that second pixel is pending. mem_we and mem_re are never high together.
- R7: If the pixel count of a write transfer is odd, the upper half of its last word is discarded without a memory write.
- R8: A pause in the input stream, including one in the middle of a row, keeps the position. busy and in_ready stay high, and the next word continues at the following pixel.
- R9: In a read transfer, mem_rdata is taken one cycle after mem_re. The first pixel fetched appears in out_data[15:0] and the second in out_data[31:16]. If the pixel count is odd, out_data[31:16] of the last word is 0. out_data stays stable while out_valid is high and out_ready is low.
- R10: img_ready rises the cycle after a non-empty read start and falls the cycle after the last read word is accepted. While img_ready is high, no memory write occurs.
- R11: done is a single-cycle pulse in the cycle after the last pixel is written, or after the last read word is accepted.
- R12: A start with zero width or zero height makes no memory access, keeps busy and img_ready low, and pulses done in the next cycle.
- R13: A start while a transfer is unfinished abandons that transfer without a done pulse. A write start also clears img_ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a new transfer (one-cycle strobe) |
| start_pos | input | 32 | Position word: column in bits 9:0, row in bits 24:16 |
| start_size | input | 32 | Size word: width in bits 15:0, height in bits 31:16 |
| start_read | input | 1 | 1 = memory to stream, 0 = stream to memory |
| in_valid | input | 1 | Input word present |
| in_data | input | 32 | Two pixels to write |
| in_ready | output | 1 | Input word accepted when in_valid is also high |
| out_valid | output | 1 | Packed read word present |
| out_data | output | 32 | Two pixels read |
| out_ready | input | 1 | Consumer takes out_data |
| mem_we | output | 1 | Frame memory write strobe |
| mem_re | output | 1 | Frame memory read strobe |
| mem_addr | output | 19 | Halfword address, row in the upper 9 bits |
| mem_wdata | output | 16 | Pixel to write |
| mem_rdata | input | 16 | Pixel read, valid one cycle after mem_re |
| busy | output | 1 | Transfer in progress |
| img_ready | output | 1 | Read data pending for the consumer |
| done | output | 1 | Transfer completion pulse |

## Verification
The bench builds the engine with its default parameters: 10 column bits, 9 row bits, 16-bit length fields and low-half-first packing. Only these full-size fields let a rectangle placed at column 1022, row 511 cross both the column wrap and the row wrap. The sparse memory model lets any address of the full 512K halfword space be written and read back, so a rectangle written in one direction is read back in the other. With 16-bit lengths, odd widths, zero widths and zero heights can all be given, which covers the discarded-half and empty-transfer cases.

// File: rtl/vrt_pkg.sv
package vrt_pkg;

   // bit position where the row field of the position word starts
   localparam int POS_ROW_LSB  = 16;
   // bit position where the height field of the size word starts
   localparam int SIZE_HGT_LSB = 16;

   typedef enum logic [2:0] {
      RP_IDLE,
      RP_FETCH_A,
      RP_FETCH_B,
      RP_CATCH_B,
      RP_CATCH_A,
      RP_SHOW
   } rd_phase_e;

endpackage

// File: rtl/vrt_walker.sv
module vrt_walker #(
   parameter int X_BITS = 10,
   parameter int Y_BITS = 9,
   parameter int LEN_W  = 16
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     load,
   input  logic [X_BITS-1:0]        ld_col,
   input  logic [Y_BITS-1:0]        ld_row,
   input  logic [LEN_W-1:0]         ld_wid,
   input  logic [LEN_W-1:0]         ld_hgt,
   input  logic                     step,
   output logic [X_BITS+Y_BITS-1:0] addr,
   output logic                     active,
   output logic                     last
);
   localparam logic [LEN_W-1:0] ONE = LEN_W'(1);

   logic [X_BITS-1:0] col_q;
   logic [Y_BITS-1:0] row_q;
   logic [LEN_W-1:0]  wid_q, rows_q, ofs_q;
   logic [X_BITS-1:0] cur_col;
   logic              row_end;

   assign cur_col = col_q + ofs_q[X_BITS-1:0];
   assign addr    = {row_q, cur_col};
   assign row_end = (ofs_q + ONE) == wid_q;
   assign active  = rows_q != '0;
   assign last    = active && (rows_q == ONE) && row_end;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         col_q  <= '0;
         row_q  <= '0;
         wid_q  <= '0;
         rows_q <= '0;
         ofs_q  <= '0;
      end else if (load) begin
         col_q  <= ld_col;
         row_q  <= ld_row;
         wid_q  <= ld_wid;
         rows_q <= (ld_wid == '0) ? '0 : ld_hgt;
         ofs_q  <= '0;
      end else if (step && active) begin
         if (row_end) begin
            ofs_q  <= '0;
            row_q  <= row_q + 1'b1;
            rows_q <= rows_q - ONE;
         end else begin
            ofs_q  <= ofs_q + ONE;
         end
      end
   end
endmodule

// File: rtl/vrt_unpack.sv
module vrt_unpack #(
   parameter int PIX_W    = 16,
   parameter bit LO_FIRST = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               clr,
   input  logic               en,
   input  logic               walk_last,
   input  logic               in_valid,
   input  logic [2*PIX_W-1:0] in_data,
   output logic               in_ready,
   output logic               wr_en,
   output logic [PIX_W-1:0]   wr_pix,
   output logic               step,
   output logic               fin
);
   logic [PIX_W-1:0] first_pix, second_pix, hold_q;
   logic             pend_q, take;

   generate
      if (LO_FIRST) begin : g_lo_first
         assign first_pix  = in_data[PIX_W-1:0];
         assign second_pix = in_data[2*PIX_W-1:PIX_W];
      end else begin : g_hi_first
         assign first_pix  = in_data[2*PIX_W-1:PIX_W];
         assign second_pix = in_data[PIX_W-1:0];
      end
   endgenerate

   assign in_ready = en && !pend_q;
   assign take     = in_valid && in_ready;

   always_comb begin
      wr_en  = pend_q || take;
      wr_pix = pend_q ? hold_q : first_pix;
      step   = wr_en;
      fin    = wr_en && walk_last;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pend_q <= 1'b0;
         hold_q <= '0;
      end else if (clr) begin
         pend_q <= 1'b0;
      end else if (take && !walk_last) begin
         pend_q <= 1'b1;
         hold_q <= second_pix;
      end else if (pend_q) begin
         pend_q <= 1'b0;
      end
   end
endmodule

// File: rtl/vrt_pack.sv
module vrt_pack
   import vrt_pkg::*;
#(
   parameter int PIX_W    = 16,
   parameter bit LO_FIRST = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               clr,
   input  logic               kick,
   input  logic               walk_active,
   input  logic               walk_last,
   input  logic [PIX_W-1:0]   rd_pix,
   input  logic               out_ready,
   output logic               rd_en,
   output logic               step,
   output logic               out_valid,
   output logic [2*PIX_W-1:0] out_data,
   output logic               fin,
   output logic               pend
);
   rd_phase_e        ph_q;
   logic [PIX_W-1:0] pa_q, pb_q;

   assign rd_en     = (ph_q == RP_FETCH_A) || (ph_q == RP_FETCH_B);
   assign step      = rd_en;
   assign out_valid = ph_q == RP_SHOW;
   assign fin       = out_valid && out_ready && !walk_active;
   assign pend      = ph_q != RP_IDLE;

   generate
      if (LO_FIRST) begin : g_lo_first
         assign out_data = {pb_q, pa_q};
      end else begin : g_hi_first
         assign out_data = {pa_q, pb_q};
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ph_q <= RP_IDLE;
         pa_q <= '0;
         pb_q <= '0;
      end else if (clr) begin
         ph_q <= kick ? RP_FETCH_A : RP_IDLE;
      end else begin
         case (ph_q)
            RP_FETCH_A: ph_q <= walk_last ? RP_CATCH_A : RP_FETCH_B;
            RP_FETCH_B: begin
               pa_q <= rd_pix;
               ph_q <= RP_CATCH_B;
            end
            RP_CATCH_B: begin
               pb_q <= rd_pix;
               ph_q <= RP_SHOW;
            end
            RP_CATCH_A: begin
               pa_q <= rd_pix;
               pb_q <= '0;
               ph_q <= RP_SHOW;
            end
            RP_SHOW: if (out_ready) ph_q <= walk_active ? RP_FETCH_A : RP_IDLE;
            default: ph_q <= RP_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/vram_xfer_engine.sv
module vram_xfer_engine
   import vrt_pkg::*;
#(
   parameter int X_BITS   = 10,
   parameter int Y_BITS   = 9,
   parameter int LEN_W    = 16,
   parameter int PIX_W    = 16,
   parameter bit LO_FIRST = 1'b1
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     start,
   input  logic [31:0]              start_pos,
   input  logic [31:0]              start_size,
   input  logic                     start_read,
   input  logic                     in_valid,
   input  logic [2*PIX_W-1:0]       in_data,
   output logic                     in_ready,
   output logic                     out_valid,
   output logic [2*PIX_W-1:0]       out_data,
   input  logic                     out_ready,
   output logic                     mem_we,
   output logic                     mem_re,
   output logic [X_BITS+Y_BITS-1:0] mem_addr,
   output logic [PIX_W-1:0]         mem_wdata,
   input  logic [PIX_W-1:0]         mem_rdata,
   output logic                     busy,
   output logic                     img_ready,
   output logic                     done
);
   generate
      if (X_BITS < 1 || X_BITS > POS_ROW_LSB || Y_BITS < 1 || Y_BITS > 32 - POS_ROW_LSB) begin : g_bad_pos
         $error("vram_xfer_engine: position field widths do not fit the position word");
      end
      if (LEN_W < X_BITS || LEN_W > SIZE_HGT_LSB) begin : g_bad_len
         $error("vram_xfer_engine: LEN_W must cover X_BITS and fit the size word");
      end
      if (PIX_W < 1) begin : g_bad_pix
         $error("vram_xfer_engine: PIX_W must be positive");
      end
   endgenerate

   logic [LEN_W-1:0] ld_wid, ld_hgt;
   logic             empty, kick, rd_mode_q, done_q, img_q;
   logic             walk_active, walk_last, step;
   logic             wr_step, wr_fin, rd_step, rd_fin, rd_pend;
   logic             unused_fields;

   assign ld_wid        = start_size[LEN_W-1:0];
   assign ld_hgt        = start_size[SIZE_HGT_LSB +: LEN_W];
   assign empty         = (ld_wid == '0) || (ld_hgt == '0);
   assign kick          = start && start_read && !empty;
   assign step          = wr_step || rd_step;
   assign unused_fields = ^{start_pos, start_size};

   vrt_walker #(.X_BITS(X_BITS), .Y_BITS(Y_BITS), .LEN_W(LEN_W)) u_walk (
      .clk    (clk),
      .rst_n  (rst_n),
      .load   (start),
      .ld_col (start_pos[X_BITS-1:0]),
      .ld_row (start_pos[POS_ROW_LSB +: Y_BITS]),
      .ld_wid (ld_wid),
      .ld_hgt (ld_hgt),
      .step   (step),
      .addr   (mem_addr),
      .active (walk_active),
      .last   (walk_last)
   );

   vrt_unpack #(.PIX_W(PIX_W), .LO_FIRST(LO_FIRST)) u_unpack (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr       (start),
      .en        (walk_active && !rd_mode_q),
      .walk_last (walk_last),
      .in_valid  (in_valid),
      .in_data   (in_data),
      .in_ready  (in_ready),
      .wr_en     (mem_we),
      .wr_pix    (mem_wdata),
      .step      (wr_step),
      .fin       (wr_fin)
   );

   vrt_pack #(.PIX_W(PIX_W), .LO_FIRST(LO_FIRST)) u_pack (
      .clk         (clk),
      .rst_n       (rst_n),
      .clr         (start),
      .kick        (kick),
      .walk_active (walk_active),
      .walk_last   (walk_last),
      .rd_pix      (mem_rdata),
      .out_ready   (out_ready),
      .rd_en       (mem_re),
      .step        (rd_step),
      .out_valid   (out_valid),
      .out_data    (out_data),
      .fin         (rd_fin),
      .pend        (rd_pend)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rd_mode_q <= 1'b0;
         done_q    <= 1'b0;
         img_q     <= 1'b0;
      end else begin
         done_q <= wr_fin || rd_fin || (start && empty);
         if (start) begin
            rd_mode_q <= start_read;
            img_q     <= kick;
         end else if (rd_fin) begin
            img_q     <= 1'b0;
         end
      end
   end

   assign busy      = walk_active || rd_pend;
   assign img_ready = img_q;
   assign done      = done_q;
endmodule

// File: rtl/vrt_chk.sv
module vrt_chk #(
   parameter int LEN_W = 16,
   parameter int PIX_W = 16
) (
   input logic               clk,
   input logic               rst_n,
   input logic               start,
   input logic [31:0]        start_size,
   input logic               in_ready,
   input logic               out_valid,
   input logic               out_ready,
   input logic [2*PIX_W-1:0] out_data,
   input logic               mem_we,
   input logic               mem_re,
   input logic               busy,
   input logic               img_ready,
   input logic               done
);
   // R6
   access_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(mem_we && mem_re));

   // R8
   ready_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      in_ready |-> busy);

   // R9
   out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready && !start) |=> (out_valid && $stable(out_data)));

   // R10
   img_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      img_ready |-> !mem_we);

   // R11
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !start && !$past(start)) |=> !done);

   // R12
   empty_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (start && (start_size[LEN_W-1:0] == '0)) |=> (done && !busy));
endmodule

bind vram_xfer_engine vrt_chk #(.LEN_W(LEN_W), .PIX_W(PIX_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .start      (start),
   .start_size (start_size),
   .in_ready   (in_ready),
   .out_valid  (out_valid),
   .out_ready  (out_ready),
   .out_data   (out_data),
   .mem_we     (mem_we),
   .mem_re     (mem_re),
   .busy       (busy),
   .img_ready  (img_ready),
   .done       (done)
);

// File: tb/tb_vram_xfer_engine.sv
`timescale 1ns/100ps
module tb_vram_xfer_engine;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [31:0] start_pos = '0;
   logic [31:0] start_size = '0;
   logic        start_read = 1'b0;
   logic        in_valid = 1'b0;
   logic [31:0] in_data = '0;
   logic        in_ready;
   logic        out_valid;
   logic [31:0] out_data;
   logic        out_ready = 1'b0;
   logic        mem_we, mem_re;
   logic [18:0] mem_addr;
   logic [15:0] mem_wdata;
   logic [15:0] mem_rdata = '0;
   logic        busy, img_ready, done;

   int checks = 0;
   int fails  = 0;
   int done_cnt = 0;
   int re_cnt = 0;

   logic [15:0] mem [int];
   int          qa[$];
   logic [15:0] qd[$];
   logic [31:0] qr[$];
   int mx, my, mw, mh, mo;

   always #2.5 clk = ~clk;

   vram_xfer_engine dut (
      .clk(clk), .rst_n(rst_n), .start(start), .start_pos(start_pos),
      .start_size(start_size), .start_read(start_read), .in_valid(in_valid),
      .in_data(in_data), .in_ready(in_ready), .out_valid(out_valid),
      .out_data(out_data), .out_ready(out_ready), .mem_we(mem_we), .mem_re(mem_re),
      .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
      .busy(busy), .img_ready(img_ready), .done(done)
   );

   function automatic logic [15:0] memval(int a);
      if (mem.exists(a)) return mem[a];
      return 16'(a * 37) ^ 16'h5a3c;
   endfunction

   // memory model: one-cycle read latency
   always @(posedge clk) begin
      if (mem_we) mem[int'(mem_addr)] = mem_wdata;
      if (mem_re) mem_rdata <= memval(int'(mem_addr));
   end

   // reference cursor
   function automatic bit mact();
      return (mh > 0) && (mw > 0);
   endfunction

   function automatic int mnext();
      int a;
      a = my * 1024 + ((mx + mo) % 1024);
      mo++;
      if (mo == mw) begin
         mo = 0;
         my = (my + 1) % 512;
         mh--;
      end
      return a;
   endfunction

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   // monitor
   always @(negedge clk) begin
      if (rst_n) begin
         if (mem_we) begin
            if (qa.size() == 0) begin
               chk(1'b0, "R7", "unexpected write addr", mem_addr, 0);
            end else begin
               int ea;
               logic [15:0] ed;
               ea = qa.pop_front();
               ed = qd.pop_front();
               chk(int'(mem_addr) == ea, "R2", "write address", mem_addr, ea);
               chk(mem_wdata == ed, "R6", "write pixel", mem_wdata, ed);
            end
         end
         if (out_valid && out_ready) begin
            if (qr.size() == 0) begin
               chk(1'b0, "R9", "unexpected read word", out_data, 0);
            end else begin
               logic [31:0] ew;
               ew = qr.pop_front();
               chk(out_data == ew, "R9", "read word", out_data, ew);
            end
         end
         if (done) done_cnt++;
         if (mem_re) re_cnt++;
      end
   end

   task automatic idle(input int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic do_start(input int x, input int y, input int w, input int h,
                           input bit rd, input bit junk);
      @(posedge clk); #1;
      start      = 1'b1;
      start_pos  = (32'(y) << 16) | 32'(x) | (junk ? 32'hFE00_FC00 : 32'h0);
      start_size = (32'(h) << 16) | 32'(w);
      start_read = rd;
      mx = x; my = y; mw = w; mh = h; mo = 0;
      @(posedge clk); #1;
      start = 1'b0;
   endtask

   task automatic send_words(input int n);
      for (int i = 0; i < n; i++) begin
         logic [31:0] wd;
         wd = $urandom;
         qa.push_back(mnext());
         qd.push_back(wd[15:0]);
         if (mact()) begin
            qa.push_back(mnext());
            qd.push_back(wd[31:16]);
         end
         in_valid = 1'b1;
         in_data  = wd;
         do @(negedge clk); while (!in_ready);
         @(posedge clk); #1;
         in_valid = 1'b0;
      end
   endtask

   task automatic pull_words(input int n);
      for (int i = 0; i < n; i++) begin
         logic [15:0] lo, hi;
         lo = memval(mnext());
         hi = mact() ? memval(mnext()) : 16'h0;
         qr.push_back({hi, lo});
         out_ready = 1'b1;
         do @(negedge clk); while (!out_valid);
         @(posedge clk); #1;
         out_ready = 1'b0;
      end
   endtask

   initial begin
      #500000;
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   end

   initial begin
      int d0, r0;
      logic [31:0] held;
      repeat (3) @(posedge clk);
      @(negedge clk);
      // R1 reset state
      chk(!busy && !done && !img_ready, "R1", "status after reset", {busy, done, img_ready}, 0);
      chk(!in_ready && !out_valid && !mem_we && !mem_re, "R1", "handshakes after reset",
          {in_ready, out_valid, mem_we, mem_re}, 0);
      @(posedge clk); #1;
      rst_n = 1'b1;

      // R2 R3 R6 R11: 4x2 write, junk bits in position word
      d0 = done_cnt;
      do_start(10, 20, 4, 2, 1'b0, 1'b1);
      send_words(4);
      idle(4);
      chk(qa.size() == 0, "R3", "writes outstanding", qa.size(), 0);
      chk(done_cnt == d0 + 1, "R11", "done pulses", done_cnt - d0, 1);
      chk(!busy, "R3", "busy after transfer", busy, 0);

      // R3: odd width, word straddles a row
      do_start(100, 7, 3, 2, 1'b0, 1'b0);
      send_words(3);
      idle(4);
      chk(qa.size() == 0, "R3", "odd width writes outstanding", qa.size(), 0);

      // R7: odd pixel total
      d0 = done_cnt;
      do_start(200, 50, 3, 1, 1'b0, 1'b0);
      send_words(2);
      idle(4);
      chk(qa.size() == 0, "R7", "odd total writes outstanding", qa.size(), 0);
      chk(done_cnt == d0 + 1, "R7", "done after odd total", done_cnt - d0, 1);

      // R4 R5: corner wrap
      do_start(1022, 511, 4, 2, 1'b0, 1'b0);
      send_words(4);
      idle(4);
      chk(qa.size() == 0, "R4", "row wrap writes outstanding", qa.size(), 0);
      chk(mem.exists(0) && mem.exists(1023) && mem.exists(511 * 1024 + 1), "R5",
          "wrapped cells written", mem.exists(0), 1);

      // R8: pause mid-row
      d0 = done_cnt;
      do_start(300, 100, 8, 2, 1'b0, 1'b0);
      send_words(3);
      idle(10);
      chk(busy && in_ready, "R8", "busy/in_ready during pause", {busy, in_ready}, 3);
      chk(done_cnt == d0, "R8", "no done during pause", done_cnt - d0, 0);
      send_words(5);
      idle(4);
      chk(qa.size() == 0 && done_cnt == d0 + 1, "R8", "resumed burst complete", qa.size(), 0);

      // R9 R10: read back the first rectangle with a stall
      do_start(10, 20, 4, 2, 1'b1, 1'b0);
      @(negedge clk);
      chk(img_ready, "R10", "img_ready after read start", img_ready, 1);
      pull_words(2);
      repeat (10) @(negedge clk);
      chk(out_valid, "R9", "word waiting", out_valid, 1);
      held = out_data;
      repeat (4) @(negedge clk);
      chk(out_data == held, "R9", "held word stable", out_data, held);
      @(posedge clk); #1;
      pull_words(2);
      @(negedge clk);
      chk(!img_ready, "R10", "img_ready after last word", img_ready, 0);
      chk(done, "R11", "done after last read word", done, 1);
      idle(2);
      chk(qr.size() == 0 && !busy, "R9", "read words outstanding", qr.size(), 0);

      // R9: odd read pads upper half with zero
      do_start(200, 50, 3, 1, 1'b1, 1'b0);
      pull_words(2);
      idle(3);
      chk(qr.size() == 0, "R9", "odd read words outstanding", qr.size(), 0);

      // R12: empty transfers
      r0 = re_cnt;
      do_start(5, 5, 0, 5, 1'b1, 1'b0);
      @(negedge clk);
      chk(done && !busy && !img_ready, "R12", "zero width start", {done, busy, img_ready}, 4);
      do_start(5, 5, 5, 0, 1'b0, 1'b0);
      @(negedge clk);
      chk(done && !busy && !in_ready, "R12", "zero height start", {done, busy, in_ready}, 4);
      idle(4);
      chk(re_cnt == r0, "R12", "memory reads for empty", re_cnt - r0, 0);

      // R13: abort a write with a read
      d0 = done_cnt;
      do_start(400, 30, 4, 4, 1'b0, 1'b0);
      send_words(2);
      idle(3);
      do_start(10, 20, 4, 2, 1'b1, 1'b0);
      pull_words(4);
      idle(3);
      chk(done_cnt == d0 + 1, "R13", "done only for finished read", done_cnt - d0, 1);
      chk(qr.size() == 0 && qa.size() == 0, "R13", "queues after abort", qr.size(), 0);

      // R13: abort a read with a write
      do_start(10, 20, 4, 2, 1'b1, 1'b0);
      pull_words(1);
      do_start(600, 40, 2, 1, 1'b0, 1'b0);
      @(negedge clk);
      chk(!img_ready && !out_valid, "R13", "read abandoned", {img_ready, out_valid}, 0);
      @(posedge clk); #1;
      d0 = done_cnt;
      send_words(1);
      idle(3);
      chk(qa.size() == 0 && done_cnt == d0 + 1, "R13", "write after abort", qa.size(), 0);

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   end
endmodule